// File: doc/BRIEF.md
# Byte-Oriented Two-Wire Bus Master

This block is a master for a two-wire serial bus (I2C) that moves one byte at a time under register control. Software sets a divider and takes mastership through a control register. The block then drives a START and waits. Each data-register write in transmit mode clocks one byte out. The first such write after mastership is taken is the address byte, with the 7-bit target address in bits 7..1 and the read/write bit in bit 0. In receive mode, each data-register read clocks in one more byte. Dropping mastership ends the transfer with a STOP.

The block drives both lines only through pull-low enables and samples the resulting line levels. Bus occupancy is tracked from START and STOP conditions seen on the lines. An interrupt flag reports each completed byte. It can also report the moment the bus falls idle, which marks a finished STOP.

Register map (3-bit byte offset, 8-bit data):

- 0x0, divider: holds N. Every timed bus phase lasts N+1 clocks.
- 0x2, control:
  - bit 7: interrupt enable.
  - bit 5: master select.
  - bit 4: transmit (1) or receive (0).
  - bit 3: no-acknowledge on received bytes.
- 0x3, status:
  - bit 5: bus busy.
  - bit 1: interrupt flag, cleared by writing 1.
  - bit 0: acknowledge bit received.
- 0x4, data.
- 0x5, idle config: bit 7 is the idle-interrupt enable.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every register reads 0x00, both line enables are low and the interrupt output is low.
- R2: Setting master select (control bit 5) while the bus is idle pulls SDA low while SCL is released (a START), and status bit 5 (busy) then reads 1.
- R3: With divider value N, every timed phase lasts N+1 clocks, so SCL rising edges during a byte are 2*(N+1) clocks apart.
- R4: During a byte, the SDA enable changes only while SCL is held low, and bits go out most significant first.
- R5: In transmit mode, a data-register write while the block waits between bytes sends that byte; the first one after mastership is taken carries address bits 7..1 and read/write bit 0.
- R6: In transmit mode, the SDA level sampled in the ninth clock's high phase is stored in status bit 0 (0 = acknowledged).
- R7: Status bit 1 sets after each byte's ninth clock and clears on a write of 1 to it; the interrupt output equals that flag AND control bit 7.
- R8: In receive mode, a data-register read while waiting starts the next byte; the master drives the ninth bit low when control bit 3 is 0 and leaves it high when bit 3 is 1; the data register returns the last received byte, never the last written one.
- R9: Clearing master select lets a byte in progress finish with its acknowledge, then produces a STOP (SDA rises while SCL is high), after which busy reads 0.
- R10: The idle config register at offset 0x5 stores only bit 7; bits 6..0 read 0.
- R11: With idle-interrupt enable set, a falling busy flag sets status bit 1.
- R12: With idle-interrupt enable clear, a falling busy flag leaves status bit 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (data reads start a receive) |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit divider width and programs small divider values: 3 for the transmit and receive transfers, and 7 for the last transfer. This keeps each byte under 150 clocks. Two divider values let the SCL spacing be checked against two different expected periods. The longer phases of the last transfer separate the STOP's busy fall from the software flag clear, so the idle-interrupt-disabled case is seen apart from the byte flag. A pull-down slave model on the wired lines acknowledges or refuses bytes and feeds receive data. Transfers therefore cover ACK and NACK in both directions.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned BYTE_W = 8;

  localparam logic [REG_AW-1:0] A_PRESC = 3'd0;
  localparam logic [REG_AW-1:0] A_CTRL  = 3'd2;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd3;
  localparam logic [REG_AW-1:0] A_DATA  = 3'd4;
  localparam logic [REG_AW-1:0] A_IDLE  = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HOLD, S_BIT_L, S_BIT_H, S_STOP_L, S_STOP_H
  } eng_state_e;
endpackage

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o,
  output logic busy_fall_o
);
  logic scl_q, sda_q, busy_prev_q;
  logic start_det, stop_det;

  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      busy_o      <= 1'b0;
      busy_prev_q <= 1'b0;
    end else begin
      scl_q       <= scl_i;
      sda_q       <= sda_i;
      busy_prev_q <= busy_o;
      if (start_det)     busy_o <= 1'b1;
      else if (stop_det) busy_o <= 1'b0;
    end
  end

  assign busy_fall_o = busy_prev_q & ~busy_o;
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int unsigned PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               msel_i,
  input  logic               tx_i,
  input  logic               txak_i,
  input  logic               bus_busy_i,
  input  logic               launch_i,
  input  logic [BYTE_W-1:0]  tx_byte_i,
  input  logic               sda_i,
  output logic               scl_oe_o,
  output logic               sda_oe_o,
  output logic               hold_o,
  output logic               in_bits_o,
  output logic               byte_done_o,
  output logic               rx_ack_o,
  output logic [BYTE_W-1:0]  rx_byte_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(BYTE_W);

  eng_state_e st_q, st_d;
  logic [PRESC_W-1:0] cnt_q;
  logic [BYTE_W-1:0]  sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic               dir_tx_q;
  logic               timed, tick, drv_bit;

  assign timed = (st_q != S_IDLE) && (st_q != S_HOLD);
  assign tick  = timed && (cnt_q == '0);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:   if (msel_i && !bus_busy_i) st_d = S_START;
      S_START:  if (tick) st_d = S_HOLD;
      S_HOLD:   if (!msel_i) st_d = S_STOP_L;
                else if (launch_i) st_d = S_BIT_L;
      S_BIT_L:  if (tick) st_d = S_BIT_H;
      S_BIT_H:  if (tick) st_d = (idx_q == ACK_IDX) ? S_HOLD : S_BIT_L;
      S_STOP_L: if (tick) st_d = S_STOP_H;
      S_STOP_H: if (tick) st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      dir_tx_q  <= 1'b1;
      rx_ack_o  <= 1'b0;
      rx_byte_o <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_d != st_q || !timed) ? presc_i : cnt_q - 1'b1;
      if (st_q == S_HOLD && msel_i && launch_i) begin
        sh_q     <= tx_byte_i;
        idx_q    <= '0;
        dir_tx_q <= tx_i;
      end
      if (st_q == S_BIT_H && tick) begin
        if (idx_q == ACK_IDX) begin
          idx_q <= '0;
          if (dir_tx_q) rx_ack_o  <= sda_i;
          else          rx_byte_o <= sh_q;
        end else begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // data bits: drive only when sending; ack slot: drive only when receiving
  assign drv_bit = (idx_q == ACK_IDX) ? (!dir_tx_q && !txak_i)
                                      : (dir_tx_q && !sh_q[BYTE_W-1]);

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (st_q)
      S_START:  sda_oe_o = 1'b1;
      S_HOLD:   scl_oe_o = 1'b1;
      S_BIT_L:  begin scl_oe_o = 1'b1; sda_oe_o = drv_bit; end
      S_BIT_H:  sda_oe_o = drv_bit;
      S_STOP_L: begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
      S_STOP_H: sda_oe_o = 1'b1;
      default:  ;
    endcase
  end

  assign hold_o      = (st_q == S_HOLD);
  assign in_bits_o   = (st_q == S_BIT_L) || (st_q == S_BIT_H);
  assign byte_done_o = (st_q == S_BIT_H) && tick && (idx_q == ACK_IDX);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int unsigned PRESC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              irq_o
);
  logic [PRESC_W-1:0] presc_q;
  logic ie_q, msel_q, tx_q, txak_q, flag_q, idle_en_q;
  logic busy, busy_fall, hold, in_bits, byte_done, rx_ack;
  logic [BYTE_W-1:0] rx_byte;
  logic wr_data, rd_data, launch;

  assign wr_data = reg_we_i && (reg_addr_i == A_DATA);
  assign rd_data = reg_re_i && (reg_addr_i == A_DATA);
  assign launch  = hold && (tx_q ? wr_data : rd_data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q   <= '0;
      ie_q      <= 1'b0;
      msel_q    <= 1'b0;
      tx_q      <= 1'b0;
      txak_q    <= 1'b0;
      idle_en_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          A_PRESC: presc_q <= PRESC_W'(reg_wdata_i);
          A_CTRL: begin
            ie_q   <= reg_wdata_i[7];
            msel_q <= reg_wdata_i[5];
            tx_q   <= reg_wdata_i[4];
            txak_q <= reg_wdata_i[3];
          end
          A_IDLE:  idle_en_q <= reg_wdata_i[7];
          default: ;
        endcase
      end
      // set beats software clear
      if (byte_done || (busy_fall && idle_en_q)) flag_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == A_STAT && reg_wdata_i[1]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_PRESC: reg_rdata_o = BYTE_W'(presc_q);
      A_CTRL:  reg_rdata_o = {ie_q, 1'b0, msel_q, tx_q, txak_q, 3'b000};
      A_STAT:  reg_rdata_o = {2'b00, busy, 3'b000, flag_q, rx_ack};
      A_DATA:  reg_rdata_o = rx_byte;
      A_IDLE:  reg_rdata_o = {idle_en_q, 7'd0};
      default: ;
    endcase
  end

  assign irq_o = flag_q & ie_q;

  i2cm_bus_mon u_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .busy_o      (busy),
    .busy_fall_o (busy_fall)
  );

  i2cm_engine #(.PRESC_W(PRESC_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .presc_i     (presc_q),
    .msel_i      (msel_q),
    .tx_i        (tx_q),
    .txak_i      (txak_q),
    .bus_busy_i  (busy),
    .launch_i    (launch),
    .tx_byte_i   (reg_wdata_i),
    .sda_i       (sda_i),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .hold_o      (hold),
    .in_bits_o   (in_bits),
    .byte_done_o (byte_done),
    .rx_ack_o    (rx_ack),
    .rx_byte_o   (rx_byte)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic in_bits,
  input logic busy,
  input logic flag,
  input logic idle_en,
  input logic byte_done
);
  p_sda_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_bits && $past(in_bits) && !scl_oe_o && !$past(scl_oe_o)) |-> $stable(sda_oe_o));

  p_busy_on_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_i) && scl_i && $past(scl_i)) |=> busy);

  p_idle_on_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_i) && scl_i && $past(scl_i)) |=> !busy);

  p_byte_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done |=> flag);

  p_idle_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && idle_en) |=> flag);

  p_no_idle_flag_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && !idle_en && !flag && !byte_done) |=> !flag);
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_i     (sda_i),
  .scl_oe_o  (scl_oe_o),
  .sda_oe_o  (sda_oe_o),
  .in_bits   (in_bits),
  .busy      (busy),
  .flag      (flag_q),
  .idle_en   (idle_en_q),
  .byte_done (byte_done)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic scl_ln, sda_ln, slv_pull;

  int checks = 0, fails = 0, cyc = 0;

  // slave model state
  logic slv_send = 1'b0, slv_ack = 1'b1;
  logic [7:0] slv_byte = '0;
  int k = 0, slot = 15, start_cnt = 0, nbytes = 0, last_rise = 0, rise_gap = 0;
  logic slv_nak = 1'b0, scl_pv = 1'b1, sda_pv = 1'b1;
  logic [7:0] cap = '0, got_byte = '0;
  logic got_ack = 1'b1;
  logic [7:0] slv_shift;

  localparam logic [2:0] A_PRESC = 3'd0, A_CTRL = 3'd2, A_STAT = 3'd3,
                         A_DATA = 3'd4, A_IDLE = 3'd5;
  // {slave ack, byte}
  localparam logic [8:0] TX_VEC [4] = '{9'h1A4, 9'h13C, 9'h1FF, 9'h096};

  always #5ns clk = ~clk;

  assign scl_ln = ~scl_oe;
  assign sda_ln = ~(sda_oe | slv_pull);
  assign slv_shift = slv_byte << slot;
  assign slv_pull = slv_send ? (slot < 8 && !slv_nak && !slv_shift[7])
                             : (slot == 8 && slv_ack);

  i2c_byte_master i_i2c_byte_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_rdata_o(reg_rdata),
    .scl_i(scl_ln), .sda_i(sda_ln), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (scl_ln && scl_pv && sda_pv && !sda_ln) begin
      start_cnt++; k = 0; slot = 15; slv_nak = 1'b0;
    end else if (scl_ln && !scl_pv) begin
      rise_gap = cyc - last_rise; last_rise = cyc;
      if (k < 8) cap = {cap[6:0], sda_ln};
      k++;
      if (k == 9) begin
        got_byte = cap; got_ack = sda_ln; nbytes++;
        if (slv_send && sda_ln) slv_nak = 1'b1;
      end
    end else if (!scl_ln && scl_pv) begin
      if (k == 9) k = 0;
      slot = k;
    end
    scl_pv = scl_ln; sda_pv = sda_ln;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic strobe, output logic [7:0] d);
    reg_addr = a; reg_re = strobe;
    #1ns d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic wait_stat(input int bitpos, input logic val);
    logic [7:0] s;
    for (int n = 0; n < 4000; n++) begin
      rd(A_STAT, 1'b0, s);
      if (s[bitpos] == val) return;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_STAT, 1'b0, d); chk("R1 status", d, 8'h00);
    rd(A_CTRL, 1'b0, d); chk("R1 control", d, 8'h00);
    rd(A_DATA, 1'b0, d); chk("R1 data", d, 8'h00);
    rd(A_IDLE, 1'b0, d); chk("R1 idle cfg", d, 8'h00);
    chk("R1 line enables", {scl_oe, sda_oe, irq}, 3'b000);
    // R10 only bit 7 stored
    wr(A_IDLE, 8'hFF); rd(A_IDLE, 1'b0, d); chk("R10 idle cfg", d, 8'h80);

    // transmit transfer, divider 3
    wr(A_PRESC, 8'd3);
    wr(A_CTRL, 8'hB0);
    repeat (10) @(negedge clk);
    rd(A_STAT, 1'b0, d); chk("R2 busy", d[5], 1'b1);
    chk("R2 start seen", start_cnt, 1);
    for (int i = 0; i < 4; i++) begin
      slv_ack = TX_VEC[i][8];
      wr(A_DATA, TX_VEC[i][7:0]);
      wait_stat(1, 1'b1);
      chk(i == 0 ? "R5 address byte" : "R4 data byte", got_byte, TX_VEC[i][7:0]);
      rd(A_STAT, 1'b0, d); chk("R6 ack bit", d[0], !TX_VEC[i][8]);
      chk("R7 irq with enable", irq, 1'b1);
      if (i == 0) begin
        wr(A_CTRL, 8'h30); chk("R7 irq gated", irq, 1'b0);
        wr(A_CTRL, 8'hB0);
      end
      wr(A_STAT, 8'h02); rd(A_STAT, 1'b0, d); chk("R7 flag cleared", d[1], 1'b0);
    end
    chk("R5 byte count", nbytes, 4);
    chk("R3 scl spacing N=3", rise_gap, 8);
    rd(A_DATA, 1'b0, d); chk("R8 data not last written", d, 8'h00);
    wr(A_CTRL, 8'h80);
    wait_stat(5, 1'b0);
    @(negedge clk);
    rd(A_STAT, 1'b0, d); chk("R9 busy cleared", d[5], 1'b0);
    chk("R11 idle flag", d[1], 1'b1);
    wr(A_STAT, 8'h02);

    // receive transfer
    slv_ack = 1'b1;
    wr(A_CTRL, 8'hB0);
    repeat (10) @(negedge clk);
    wr(A_DATA, 8'hA5);
    wait_stat(1, 1'b1);
    wr(A_STAT, 8'h02);
    slv_byte = 8'h5A; slv_send = 1'b1;
    wr(A_CTRL, 8'hA0);
    rd(A_DATA, 1'b1, d); chk("R8 before receive", d, 8'h00);
    wait_stat(1, 1'b1);
    chk("R8 master ack", got_ack, 1'b0);
    wr(A_STAT, 8'h02);
    wr(A_CTRL, 8'hA8);
    slv_byte = 8'hC3;
    rd(A_DATA, 1'b1, d); chk("R8 first received", d, 8'h5A);
    wait_stat(1, 1'b1);
    chk("R8 master nack", got_ack, 1'b1);
    wr(A_STAT, 8'h02);
    wr(A_CTRL, 8'h80);
    wait_stat(5, 1'b0);
    slv_send = 1'b0;
    rd(A_DATA, 1'b1, d); chk("R8 second received", d, 8'hC3);
    wr(A_STAT, 8'h02);

    // idle interrupt off, stop requested mid-byte, divider 7
    wr(A_IDLE, 8'h00);
    wr(A_PRESC, 8'd7);
    wr(A_CTRL, 8'hB0);
    repeat (20) @(negedge clk);
    wr(A_DATA, 8'h40);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 8'h90);
    wait_stat(1, 1'b1);
    chk("R9 byte finishes", got_byte, 8'h40);
    chk("R3 scl spacing N=7", rise_gap, 16);
    wr(A_STAT, 8'h02);
    rd(A_STAT, 1'b0, d); chk("R12 busy before stop", d[5], 1'b1);
    wait_stat(5, 1'b0);
    repeat (5) @(negedge clk);
    rd(A_STAT, 1'b0, d); chk("R12 no idle flag", d[1], 1'b0);
    chk("R9 stop lines released", {scl_ln, sda_ln}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule